// File: doc/BRIEF.md
# Guarded Flash Erase-Block Selector

This block sits inside a flash memory controller and holds the choice of which flash block the next erase cycle may touch. Two 8-bit select registers, one for the lower group of blocks and one for the upper group, are joined into a 16-bit erase-select bus for the flash array. Setting a bit unlocks erase of that one block, and every other block stays protected. The registers are guarded. A write that would leave more than one block chosen across both registers wipes both to zero. The registers also fall to zero whenever the write-enable pin, the standby states or the software-enable bits say that erasing is not allowed.

The block also keeps the program-mode bit for the upper flash bank, which covers addresses 0x040000 to 0x07FFFF. Software may set this bit only while the write-enable pin, the upper-bank software-enable bit and the upper-bank program-setup bit are all high. It falls back to zero as soon as any of the three drops. When on-chip flash is disabled, the select registers read as zero and ignore writes.

Top module: `flash_erase_sel`

## Requirements
- R1: After reset, both select registers read 0x00, `erase_sel` is 0 and `prog_mode` is 0.
- R2: A cycle with `hw_standby` or `sw_standby` high clears both select registers at the next clock edge.
- R3: A cycle with `wren_pin` low clears both select registers at the next clock edge.
- R4: A cycle with `wren_pin` high and `sw_en_lo` low clears only the lower select register at the next clock edge, and a write to it in that cycle is dropped. The upper register keeps its value.
- R5: With flash enabled and no clear condition, a write to address 0 (lower register) or address 1 (upper register) that leaves at most one bit set is stored at the next edge. `erase_sel` equals {upper, lower}, so lower bit i drives `erase_sel[i]` and upper bit i drives `erase_sel[8+i]`.
- R6: A write whose result, counted across both registers together, would have more than one bit set clears both registers to zero. This includes a single-bit write when the other register already holds a bit.
- R7: While `flash_on` is low, reads of addresses 0 and 1 return 0x00 and writes to them leave both registers unchanged.
- R8: `prog_mode` becomes 1 only through a write of 1 to bit 0 of address 2 in a cycle where `wren_pin`, `sw_en_hi` and `prog_setup_hi` are all 1. A write of 1 in any other cycle leaves it at 0.
- R9: `prog_mode` is 0 in the cycle after any of `wren_pin`, `sw_en_hi` or `prog_setup_hi` is low.
- R10: `erase_sel` never has more than one bit set.
- R11: With flash enabled, reading address 0, 1 or 2 returns the lower register, the upper register, or `prog_mode` in bit 0. Any other address reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_standby | input | 1 | Hardware standby active |
| sw_standby | input | 1 | Software standby active |
| wren_pin | input | 1 | Flash write-enable pin level |
| sw_en_lo | input | 1 | Software-enable bit for the lower bank |
| sw_en_hi | input | 1 | Software-enable bit for the upper bank |
| prog_setup_hi | input | 1 | Upper-bank program-setup bit |
| flash_on | input | 1 | On-chip flash enabled |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 lower select, 1 upper select, 2 program control |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| erase_sel | output | 16 | One-hot erase-block select, {upper, lower} |
| prog_mode | output | 1 | Upper-bank program-mode strobe |

## Verification
The hardest case to reach is the one-hot wipe triggered by a single-bit write. It fires only when the other register already holds a bit, so the bench first loads one register legally and then writes one bit into the other, and it does this in both directions. The clear that touches only the lower register is also hard to see. The bench parks a bit in the upper register and a different bit in the lower register on separate passes, drops `sw_en_lo` for one cycle, and checks which half of `erase_sel` survives. Dropped writes are checked the same way: the bench writes while flash is off, or while the lower clear is active, and then reads the registers back once the condition is lifted.

// File: rtl/flash_erase_sel.sv
module flash_erase_sel #(
  parameter int SEL_W  = 8,
  parameter int ADDR_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hw_standby,
  input  logic                sw_standby,
  input  logic                wren_pin,
  input  logic                sw_en_lo,
  input  logic                sw_en_hi,
  input  logic                prog_setup_hi,
  input  logic                flash_on,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [SEL_W-1:0]    wr_data,
  output logic [SEL_W-1:0]    rd_data,
  output logic [2*SEL_W-1:0]  erase_sel,
  output logic                prog_mode
);
  localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_PROG = ADDR_W'(2);

  logic [SEL_W-1:0] lo_q, hi_q, lo_c, hi_c;
  logic             prog_q, multi;

  wire clr_all = hw_standby | sw_standby | ~wren_pin;
  wire clr_lo  = clr_all | ~sw_en_lo;
  wire bus_wr  = wr_en & flash_on;
  wire prog_ok = wren_pin & sw_en_hi & prog_setup_hi;

  always_comb begin
    lo_c = lo_q;
    hi_c = hi_q;
    if (bus_wr && addr == A_LO) lo_c = wr_data;
    if (bus_wr && addr == A_HI) hi_c = wr_data;
    if (clr_lo)  lo_c = '0;
    if (clr_all) hi_c = '0;
    multi = $countones({hi_c, lo_c}) > 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= multi ? '0 : lo_c;
      hi_q <= multi ? '0 : hi_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        prog_q <= 1'b0;
    else if (!prog_ok)                 prog_q <= 1'b0;
    else if (wr_en && addr == A_PROG)  prog_q <= wr_data[0];
  end

  always_comb begin
    case (addr)
      A_LO:    rd_data = flash_on ? lo_q : '0;
      A_HI:    rd_data = flash_on ? hi_q : '0;
      A_PROG:  rd_data = {{(SEL_W-1){1'b0}}, prog_q};
      default: rd_data = '0;
    endcase
  end

  assign erase_sel = {hi_q, lo_q};
  assign prog_mode = prog_q;
endmodule

// File: rtl/flash_erase_sel_chk.sv
module flash_erase_sel_chk #(
  parameter int SEL_W  = 8,
  parameter int ADDR_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               hw_standby,
  input logic               sw_standby,
  input logic               wren_pin,
  input logic               sw_en_lo,
  input logic               sw_en_hi,
  input logic               prog_setup_hi,
  input logic               flash_on,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [SEL_W-1:0]   wr_data,
  input logic [SEL_W-1:0]   rd_data,
  input logic [2*SEL_W-1:0] erase_sel,
  input logic               prog_mode
);
  localparam logic [ADDR_W-1:0] A_PROG = ADDR_W'(2);

  assert_standby_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_standby || sw_standby) |=> erase_sel == '0);

  assert_pin_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wren_pin |=> erase_sel == '0);

  assert_lo_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wren_pin && !sw_en_lo) |=> erase_sel[SEL_W-1:0] == '0);

  assert_off_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_on && addr < ADDR_W'(2)) |-> rd_data == '0);

  assert_off_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_on && wren_pin && sw_en_lo && !hw_standby && !sw_standby)
      |=> erase_sel == $past(erase_sel));

  assert_prog_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_mode) |-> $past(wr_en && addr == A_PROG && wr_data[0]
                               && wren_pin && sw_en_hi && prog_setup_hi));

  assert_prog_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wren_pin && sw_en_hi && prog_setup_hi) |=> !prog_mode);

  assert_one_hot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(erase_sel));
endmodule

bind flash_erase_sel flash_erase_sel_chk #(.SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_standby(hw_standby), .sw_standby(sw_standby),
  .wren_pin(wren_pin), .sw_en_lo(sw_en_lo), .sw_en_hi(sw_en_hi),
  .prog_setup_hi(prog_setup_hi), .flash_on(flash_on), .wr_en(wr_en),
  .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
  .erase_sel(erase_sel), .prog_mode(prog_mode)
);

// File: tb/flash_erase_sel_bench.sv
module flash_erase_sel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hw_standby = 1'b0, sw_standby = 1'b0, wren_pin = 1'b1;
  logic        sw_en_lo = 1'b1, sw_en_hi = 1'b1, prog_setup_hi = 1'b0;
  logic        flash_on = 1'b1, wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [7:0]  wr_data = 8'h00;
  logic [7:0]  rd_data;
  logic [15:0] erase_sel;
  logic        prog_mode;
  int          checks = 0, fails = 0, hot_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  flash_erase_sel u_flash_erase_sel (
    .clk(clk), .rst_n(rst_n), .hw_standby(hw_standby), .sw_standby(sw_standby),
    .wren_pin(wren_pin), .sw_en_lo(sw_en_lo), .sw_en_hi(sw_en_hi),
    .prog_setup_hi(prog_setup_hi), .flash_on(flash_on), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .erase_sel(erase_sel), .prog_mode(prog_mode)
  );

  always @(negedge clk) if (rst_n && $countones(erase_sel) > 1) hot_bad++;

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rd_data;
  endtask

  task automatic pulse(ref logic sig, input logic lvl);
    @(negedge clk); sig = lvl;
    @(negedge clk); sig = ~lvl;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(2'd0, d); check("R1 lo", {8'h0, d}, 16'h0);
    rd(2'd1, d); check("R1 hi", {8'h0, d}, 16'h0);
    rd(2'd2, d); check("R1 prog", {8'h0, d}, 16'h0);
    check("R1 sel", erase_sel, 16'h0);
    check("R1 mode", {15'h0, prog_mode}, 16'h0);
  endtask

  task automatic t_onehot();
    logic [7:0] d;
    wr(2'd0, 8'h04); check("R5 lo", erase_sel, 16'h0004);
    rd(2'd0, d); check("R11 lo", {8'h0, d}, 16'h0004);
    wr(2'd1, 8'h80); check("R6 cross hi", erase_sel, 16'h0);
    wr(2'd0, 8'h03); check("R6 two bits", erase_sel, 16'h0);
    wr(2'd1, 8'h10); check("R5 hi", erase_sel, 16'h1000);
    rd(2'd1, d); check("R11 hi", {8'h0, d}, 16'h0010);
    wr(2'd0, 8'h01); check("R6 cross lo", erase_sel, 16'h0);
    wr(2'd1, 8'h10); check("R5 reload", erase_sel, 16'h1000);
    rd(2'd3, d); check("R11 unused", {8'h0, d}, 16'h0);
  endtask

  task automatic t_flash_off();
    logic [7:0] d;
    flash_on = 1'b0;
    rd(2'd1, d); check("R7 read", {8'h0, d}, 16'h0);
    wr(2'd1, 8'h00); check("R7 write hi", erase_sel, 16'h1000);
    wr(2'd0, 8'h01); check("R7 write lo", erase_sel, 16'h1000);
    flash_on = 1'b1;
    rd(2'd1, d); check("R7 restore", {8'h0, d}, 16'h0010);
  endtask

  task automatic t_lo_clear();
    pulse(sw_en_lo, 1'b0); check("R4 hi kept", erase_sel, 16'h1000);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h02); check("R4 setup", erase_sel, 16'h0002);
    pulse(sw_en_lo, 1'b0); check("R4 lo cleared", erase_sel, 16'h0);
    sw_en_lo = 1'b0;
    wr(2'd0, 8'h20); check("R4 write dropped", erase_sel, 16'h0);
    sw_en_lo = 1'b1;
    @(negedge clk); check("R4 still zero", erase_sel, 16'h0);
  endtask

  task automatic t_pin_standby();
    wr(2'd1, 8'h01); check("R5 hi bit0", erase_sel, 16'h0100);
    pulse(wren_pin, 1'b0); check("R3 pin low", erase_sel, 16'h0);
    wr(2'd0, 8'h08); check("R5 lo bit3", erase_sel, 16'h0008);
    pulse(hw_standby, 1'b1); check("R2 hw standby", erase_sel, 16'h0);
    wr(2'd1, 8'h40); check("R5 hi bit6", erase_sel, 16'h4000);
    pulse(sw_standby, 1'b1); check("R2 sw standby", erase_sel, 16'h0);
  endtask

  task automatic t_prog();
    logic [7:0] d;
    prog_setup_hi = 1'b0;
    wr(2'd2, 8'h01); check("R8 no setup", {15'h0, prog_mode}, 16'h0);
    prog_setup_hi = 1'b1; sw_en_hi = 1'b0;
    wr(2'd2, 8'h01); check("R8 no swen", {15'h0, prog_mode}, 16'h0);
    sw_en_hi = 1'b1;
    wr(2'd2, 8'h01); check("R8 set", {15'h0, prog_mode}, 16'h1);
    rd(2'd2, d); check("R11 prog", {8'h0, d}, 16'h0001);
    pulse(sw_en_hi, 1'b0); check("R9 swen drop", {15'h0, prog_mode}, 16'h0);
    wr(2'd2, 8'h01);
    pulse(prog_setup_hi, 1'b0); check("R9 setup drop", {15'h0, prog_mode}, 16'h0);
    wr(2'd2, 8'h01); check("R8 set again", {15'h0, prog_mode}, 16'h1);
    pulse(wren_pin, 1'b0); check("R9 pin drop", {15'h0, prog_mode}, 16'h0);
    @(negedge clk); check("R9 stays clear", {15'h0, prog_mode}, 16'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_onehot();
    t_flash_off();
    t_lo_clear();
    t_pin_standby();
    t_prog();
    check("R10 one-hot", 16'(hot_bad), 16'h0);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule